// File: doc/BRIEF.md
# Dual-Bus Operand Prefetch Address Generator

This block forms two operand addresses per cycle for multiply-accumulate style instructions: one on the X data bus and one on the Y data bus. Each bus owns two of the four dedicated prefetch pointers. The X bus uses pointers XA and XB, and the Y bus uses pointers YA and YB. The current pointer values enter on input ports. The block returns the two addresses in the same cycle, together with one combinational error flag.

Each bus is driven by three controls and a mode:
- an enable;
- a one-bit pointer select (0 picks the A pointer, 1 picks the B pointer);
- an indexed-mode bit;
- a two-bit modify code.

In plain mode the pointer is the address. After the access, the pointer can be stepped by 2, 4 or 6. In indexed mode the bus offset register is added to the pointer to form the address, and the pointer is left unchanged. Only the B pointer of a bus may be indexed.

Every address is checked against an inclusive window [lo, hi] that belongs to its own bus. The unmodified pointer is checked, and so is the post-modified value (or, in indexed mode, the effective address). Any violation, or any illegal index request, raises the error flag. When the flag is raised, no pointer writeback happens on either bus that cycle.

Pointer updates for both buses are registered. On the next clock edge they appear as a write enable, the pointer select and the new value, ready for the register file.

Top module: `dual_agen`

## Requirements
- R1: With the bus enabled and the indexed bit clear, `x_addr` equals the selected X pointer (`ptr_x0` when `x_sel`=0, `ptr_x1` when `x_sel`=1), and `y_addr` likewise equals `ptr_y0`/`ptr_y1`. Both are valid in the same cycle as the inputs.
- R2: With the indexed bit set and select 1, the address is the B pointer plus the bus offset (`x_ofs`/`y_ofs`), modulo 2^AW. An indexed request never produces a writeback.
- R3: The modify code selects the post-modify step: 0 gives none, 1 gives +2, 2 gives +4, 3 gives +6. When the bus is enabled, not indexed, the code is nonzero and `err` is low, the next clock edge sets the bus `*_wb_en` to 1. It also sets `*_wb_sel` to that cycle's select and `*_wb_val` to pointer plus step, modulo 2^AW. Otherwise `*_wb_en` is 0 after that edge.
- R4: An enabled bus that requests indexed mode with select 0 raises `err`.
- R5: An enabled bus whose selected pointer lies outside its inclusive window raises `err`. The X window is [`x_lo`, `x_hi`] and the Y window is [`y_lo`, `y_hi`].
- R6: An enabled bus raises `err` when its checked target lies outside its window. In plain mode the target is the post-modified value; in indexed mode it is the effective address.
- R7: A cycle with `err` high produces no writeback on either bus at the next edge, even on a bus that had no fault.
- R8: A disabled bus contributes nothing to `err` and produces no writeback, whatever its other controls and pointers hold.
- R9: Synchronous active-high reset clears both write enables, both selects and both writeback values to zero.
- R10: Each bus is checked only against its own window. An X pointer outside the Y window but inside the X window raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_en | input | 1 | X bus access enable |
| x_sel | input | 1 | X pointer select (0 = A, 1 = B) |
| x_idx | input | 1 | X indexed mode |
| x_mod | input | 2 | X post-modify code |
| y_en | input | 1 | Y bus access enable |
| y_sel | input | 1 | Y pointer select (0 = A, 1 = B) |
| y_idx | input | 1 | Y indexed mode |
| y_mod | input | 2 | Y post-modify code |
| ptr_x0 | input | AW | X pointer A |
| ptr_x1 | input | AW | X pointer B (indexable) |
| ptr_y0 | input | AW | Y pointer A |
| ptr_y1 | input | AW | Y pointer B (indexable) |
| x_ofs | input | AW | X offset register |
| y_ofs | input | AW | Y offset register |
| x_lo | input | AW | X window low bound (inclusive) |
| x_hi | input | AW | X window high bound (inclusive) |
| y_lo | input | AW | Y window low bound (inclusive) |
| y_hi | input | AW | Y window high bound (inclusive) |
| x_addr | output | AW | X effective address |
| y_addr | output | AW | Y effective address |
| err | output | 1 | Address or mode fault this cycle |
| x_wb_en | output | 1 | X pointer writeback enable |
| x_wb_sel | output | 1 | X pointer being written |
| x_wb_val | output | AW | X pointer new value |
| y_wb_en | output | 1 | Y pointer writeback enable |
| y_wb_sel | output | 1 | Y pointer being written |
| y_wb_val | output | AW | Y pointer new value |

## Verification
The bench pushes pointers onto the exact window edges.

- **Last word of the window.** A pointer at `hi-1` stepped by +2 lands one past the window. A design that checks only the unmodified pointer would miss this and write the pointer back.
- **Wrap of the step sum.** A step from the top of the address space wraps to zero. A design that carries the sum into a wider comparison would flag this wrongly.
- **Fault on one bus only.** A fault on one bus paired with a clean access on the other catches a design that gates only the faulty bus.
- **Illegal index and disabled bus.** An index request on the A pointer must raise the error. A disabled bus holding wild pointers must not raise it.

// File: rtl/dual_agen_pkg.sv
package dual_agen_pkg;

    typedef enum logic [1:0] {
        MOD_NONE = 2'd0,
        MOD_P2   = 2'd1,
        MOD_P4   = 2'd2,
        MOD_P6   = 2'd3
    } mod_e;

    typedef struct packed {
        logic en;
        logic sel;
        logic idx;
        mod_e mod;
    } lane_ctl_t;

    localparam int NLANE = 2;
    localparam int LANE_X = 0;
    localparam int LANE_Y = 1;

    function automatic logic [3:0] step_bytes(input mod_e m);
        case (m)
            MOD_P2:  return 4'd2;
            MOD_P4:  return 4'd4;
            MOD_P6:  return 4'd6;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/dual_agen_lane.sv
module dual_agen_lane
    import dual_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  lane_ctl_t        ctl,
    input  logic [AW-1:0]    ptr_a,
    input  logic [AW-1:0]    ptr_b,
    input  logic [AW-1:0]    ofs,
    input  logic [AW-1:0]    lo,
    input  logic [AW-1:0]    hi,
    output logic [AW-1:0]    ea,
    output logic [AW-1:0]    nxt,
    output logic             want_wb,
    output logic             fault
);
    localparam int PADW = AW - 4;

    logic [AW-1:0] base;
    logic [AW-1:0] target;
    logic          illegal;
    logic          base_ok;
    logic          tgt_ok;

    always_comb begin
        base    = ctl.sel ? ptr_b : ptr_a;
        ea      = ctl.idx ? (base + ofs) : base;
        nxt     = base + {{PADW{1'b0}}, step_bytes(ctl.mod)};
        target  = ctl.idx ? ea : nxt;
        illegal = ctl.idx & ~ctl.sel;
        base_ok = (base >= lo) && (base <= hi);
        tgt_ok  = (target >= lo) && (target <= hi);
        fault   = ctl.en & (illegal | ~base_ok | ~tgt_ok);
        want_wb = ctl.en & ~ctl.idx & (ctl.mod != MOD_NONE);
    end

endmodule

// File: rtl/dual_agen_commit.sv
module dual_agen_commit
    import dual_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       err,
    input  logic [NLANE-1:0]           want,
    input  logic [NLANE-1:0]           sel,
    input  logic [NLANE-1:0][AW-1:0]   nxt,
    output logic [NLANE-1:0]           wb_en,
    output logic [NLANE-1:0]           wb_sel,
    output logic [NLANE-1:0][AW-1:0]   wb_val
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                wb_en[g]  <= 1'b0;
                wb_sel[g] <= 1'b0;
                wb_val[g] <= '0;
            end else begin
                wb_en[g]  <= want[g] & ~err;
                wb_sel[g] <= sel[g];
                wb_val[g] <= nxt[g];
            end
        end
    end

endmodule

// File: rtl/dual_agen.sv
module dual_agen
    import dual_agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          x_en,
    input  logic          x_sel,
    input  logic          x_idx,
    input  logic [1:0]    x_mod,
    input  logic          y_en,
    input  logic          y_sel,
    input  logic          y_idx,
    input  logic [1:0]    y_mod,
    input  logic [AW-1:0] ptr_x0,
    input  logic [AW-1:0] ptr_x1,
    input  logic [AW-1:0] ptr_y0,
    input  logic [AW-1:0] ptr_y1,
    input  logic [AW-1:0] x_ofs,
    input  logic [AW-1:0] y_ofs,
    input  logic [AW-1:0] x_lo,
    input  logic [AW-1:0] x_hi,
    input  logic [AW-1:0] y_lo,
    input  logic [AW-1:0] y_hi,
    output logic [AW-1:0] x_addr,
    output logic [AW-1:0] y_addr,
    output logic          err,
    output logic          x_wb_en,
    output logic          x_wb_sel,
    output logic [AW-1:0] x_wb_val,
    output logic          y_wb_en,
    output logic          y_wb_sel,
    output logic [AW-1:0] y_wb_val
);
    lane_ctl_t [NLANE-1:0]         ctl;
    logic [NLANE-1:0][AW-1:0]      pa, pb, ofs, lo, hi, ea, nxt, wb_val;
    logic [NLANE-1:0]              want, fault, sel, wb_en, wb_sel;

    assign ctl[LANE_X] = '{en: x_en, sel: x_sel, idx: x_idx, mod: mod_e'(x_mod)};
    assign ctl[LANE_Y] = '{en: y_en, sel: y_sel, idx: y_idx, mod: mod_e'(y_mod)};
    assign pa[LANE_X]  = ptr_x0;
    assign pb[LANE_X]  = ptr_x1;
    assign pa[LANE_Y]  = ptr_y0;
    assign pb[LANE_Y]  = ptr_y1;
    assign ofs[LANE_X] = x_ofs;
    assign ofs[LANE_Y] = y_ofs;
    assign lo[LANE_X]  = x_lo;
    assign lo[LANE_Y]  = y_lo;
    assign hi[LANE_X]  = x_hi;
    assign hi[LANE_Y]  = y_hi;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign sel[g] = ctl[g].sel;
        dual_agen_lane #(.AW(AW)) u_lane (
            .ctl     (ctl[g]),
            .ptr_a   (pa[g]),
            .ptr_b   (pb[g]),
            .ofs     (ofs[g]),
            .lo      (lo[g]),
            .hi      (hi[g]),
            .ea      (ea[g]),
            .nxt     (nxt[g]),
            .want_wb (want[g]),
            .fault   (fault[g])
        );
    end

    assign err = |fault;

    dual_agen_commit #(.AW(AW)) u_commit (
        .clk    (clk),
        .rst    (rst),
        .err    (err),
        .want   (want),
        .sel    (sel),
        .nxt    (nxt),
        .wb_en  (wb_en),
        .wb_sel (wb_sel),
        .wb_val (wb_val)
    );

    assign x_addr   = ea[LANE_X];
    assign y_addr   = ea[LANE_Y];
    assign x_wb_en  = wb_en[LANE_X];
    assign y_wb_en  = wb_en[LANE_Y];
    assign x_wb_sel = wb_sel[LANE_X];
    assign y_wb_sel = wb_sel[LANE_Y];
    assign x_wb_val = wb_val[LANE_X];
    assign y_wb_val = wb_val[LANE_Y];

endmodule

// File: rtl/dual_agen_chk.sv
module dual_agen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          x_en,
    input logic          x_sel,
    input logic          x_idx,
    input logic [1:0]    x_mod,
    input logic          y_en,
    input logic          y_sel,
    input logic          y_idx,
    input logic [AW-1:0] ptr_x0,
    input logic [AW-1:0] ptr_x1,
    input logic [AW-1:0] x_lo,
    input logic [AW-1:0] x_hi,
    input logic [AW-1:0] x_addr,
    input logic          err,
    input logic          x_wb_en,
    input logic [AW-1:0] x_wb_val,
    input logic          y_wb_en
);
    // R1
    x_plain_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (x_en && !x_idx) |-> x_addr == (x_sel ? ptr_x1 : ptr_x0));

    // R4
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        ((x_en && x_idx && !x_sel) || (y_en && y_idx && !y_sel)) |-> err);

    // R3
    x_wb_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && x_wb_en) |->
        x_wb_val == $past((x_sel ? ptr_x1 : ptr_x0) + AW'({x_mod, 1'b0})));

    // R7
    err_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(err)) |-> (!x_wb_en && !y_wb_en));

    // R5
    x_window_chk: assert property (@(posedge clk) disable iff (rst)
        (x_en && !x_idx && !err) |-> (x_addr >= x_lo && x_addr <= x_hi));

    // R8
    idle_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (!x_en && !y_en) |=> (!x_wb_en && !y_wb_en));

endmodule

bind dual_agen dual_agen_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .x_en     (x_en),
    .x_sel    (x_sel),
    .x_idx    (x_idx),
    .x_mod    (x_mod),
    .y_en     (y_en),
    .y_sel    (y_sel),
    .y_idx    (y_idx),
    .ptr_x0   (ptr_x0),
    .ptr_x1   (ptr_x1),
    .x_lo     (x_lo),
    .x_hi     (x_hi),
    .x_addr   (x_addr),
    .err      (err),
    .x_wb_en  (x_wb_en),
    .x_wb_val (x_wb_val),
    .y_wb_en  (y_wb_en)
);

// File: tb/sim_dual_agen.sv
`timescale 1ns/1ps
module sim_dual_agen;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_en, x_sel, x_idx, y_en, y_sel, y_idx;
    logic [1:0] x_mod, y_mod;
    logic [AW-1:0] ptr_x0, ptr_x1, ptr_y0, ptr_y1, x_ofs, y_ofs;
    logic [AW-1:0] x_lo, x_hi, y_lo, y_hi;
    logic [AW-1:0] x_addr, y_addr, x_wb_val, y_wb_val;
    logic err, x_wb_en, x_wb_sel, y_wb_en, y_wb_sel;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_agen #(.AW(AW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wrap(input int v);
        return v & ((1 << AW) - 1);
    endfunction

    function automatic bit inwin(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // per-lane reference: returns {fault, want}; address and next via refs
    function automatic void lane_ref(input bit en, input bit sel, input bit idx,
                                     input int mod, input int p0, input int p1,
                                     input int ofs, input int lo, input int hi,
                                     output int addr, output int nv,
                                     output bit flt, output bit want);
        int p;
        p    = sel ? p1 : p0;
        addr = idx ? wrap(p + ofs) : p;
        nv   = wrap(p + 2 * mod);
        flt  = 0;
        if (en) begin
            if (idx && !sel) flt = 1;
            if (!inwin(p, lo, hi)) flt = 1;
            if (idx && !inwin(addr, lo, hi)) flt = 1;
            if (!idx && !inwin(nv, lo, hi)) flt = 1;
        end
        want = en && !idx && (mod != 0);
    endfunction

    task automatic step(input string tag);
        int xa, xn, ya, yn;
        bit xf, xw, yf, yw, e;
        bit xs, ys;
        lane_ref(x_en, x_sel, x_idx, int'(x_mod), int'(ptr_x0), int'(ptr_x1),
                 int'(x_ofs), int'(x_lo), int'(x_hi), xa, xn, xf, xw);
        lane_ref(y_en, y_sel, y_idx, int'(y_mod), int'(ptr_y0), int'(ptr_y1),
                 int'(y_ofs), int'(y_lo), int'(y_hi), ya, yn, yf, yw);
        e  = xf | yf;
        xs = x_sel;
        ys = y_sel;
        #1;
        chk({tag, " R1/R2 x_addr"}, int'(x_addr), xa);
        chk({tag, " R1/R2 y_addr"}, int'(y_addr), ya);
        chk({tag, " R4/R5/R6 err"}, int'(err), int'(e));
        @(posedge clk);
        #2;
        chk({tag, " R3/R7/R8 x_wb_en"}, int'(x_wb_en), int'(xw && !e));
        chk({tag, " R3/R7/R8 y_wb_en"}, int'(y_wb_en), int'(yw && !e));
        if (xw && !e) begin
            chk({tag, " R3 x_wb_val"}, int'(x_wb_val), xn);
            chk({tag, " R3 x_wb_sel"}, int'(x_wb_sel), int'(xs));
        end
        if (yw && !e) begin
            chk({tag, " R3 y_wb_val"}, int'(y_wb_val), yn);
            chk({tag, " R3 y_wb_sel"}, int'(y_wb_sel), int'(ys));
        end
        @(negedge clk);
    endtask

    task automatic setx(input bit en, input bit s, input bit i, input logic [1:0] m);
        x_en = en; x_sel = s; x_idx = i; x_mod = m;
    endtask

    task automatic sety(input bit en, input bit s, input bit i, input logic [1:0] m);
        y_en = en; y_sel = s; y_idx = i; y_mod = m;
    endtask

    function automatic logic [AW-1:0] rnd_ptr(input logic [AW-1:0] lo,
                                              input logic [AW-1:0] hi);
        int span;
        span = int'(hi) - int'(lo) + 24;
        return AW'((int'(lo) - 12 + int'($urandom % span)) & ~1);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        setx(0, 0, 0, 0); sety(0, 0, 0, 0);
        ptr_x0 = 16'h0900; ptr_x1 = 16'h0A00; ptr_y0 = 16'h1900; ptr_y1 = 16'h1A00;
        x_ofs = 16'h0010; y_ofs = 16'h0020;
        x_lo = 16'h0800; x_hi = 16'h0FFF; y_lo = 16'h1800; y_hi = 16'h1FFF;
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        chk("R9 x_wb_en", int'(x_wb_en), 0);
        chk("R9 y_wb_en", int'(y_wb_en), 0);
        chk("R9 x_wb_val", int'(x_wb_val), 0);
        chk("R9 y_wb_sel", int'(y_wb_sel), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R3 plain with post-modify on both buses
        setx(1, 0, 0, 2'd1); sety(1, 1, 0, 2'd3);
        step("dir_plain");
        // R2 indexed on B pointers
        setx(1, 1, 1, 2'd2); sety(1, 1, 1, 2'd0);
        step("dir_index");
        // R4 indexed on A pointer
        setx(1, 0, 1, 2'd0); sety(0, 0, 0, 2'd0);
        step("dir_bad_idx");
        // R6 last word +2 steps past window; R7 blocks the clean Y bus too
        ptr_x0 = 16'h0FFE; setx(1, 0, 0, 2'd1); sety(1, 0, 0, 2'd1);
        step("dir_edge_over");
        // R6 stepping to the last even word stays inside
        ptr_x0 = 16'h0FF8; setx(1, 0, 0, 2'd3);
        step("dir_edge_in");
        // R5 pointer below window
        ptr_y1 = 16'h17FE; sety(1, 1, 0, 2'd0); setx(0, 0, 0, 0);
        step("dir_below");
        // R8 disabled bus with wild pointer and bad index
        sety(0, 0, 1, 2'd3);
        step("dir_disabled");
        // R10 X pointer inside Y window only
        ptr_x1 = 16'h1900; setx(1, 1, 0, 2'd0); sety(0, 0, 0, 0);
        step("dir_other_win");
        // R3 wrap at the top of the address space
        x_lo = 16'h0000; x_hi = 16'hFFFF; ptr_x1 = 16'hFFFE; setx(1, 1, 0, 2'd1);
        step("dir_wrap");
        // R2 indexed wrap
        x_ofs = 16'h0004; setx(1, 1, 1, 2'd0);
        step("dir_idx_wrap");
        x_lo = 16'h0800; x_hi = 16'h0FFF;

        for (int n = 0; n < 400; n++) begin
            ptr_x0 = rnd_ptr(x_lo, x_hi); ptr_x1 = rnd_ptr(x_lo, x_hi);
            ptr_y0 = rnd_ptr(y_lo, y_hi); ptr_y1 = rnd_ptr(y_lo, y_hi);
            x_ofs = AW'($urandom % 64); y_ofs = AW'($urandom % 64);
            setx(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) == 0, 2'($urandom));
            sety(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) == 0, 2'($urandom));
            step("rnd");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule